// File: doc/BRIEF.md
# Indexed Block-Transfer Register Slave

This block is a two-wire serial slave that gives a bus host access to a small bank of 8-bit configuration registers. It oversamples the clock and data lines with the system clock and synchronizes both. It recognises start, repeated-start and stop conditions. It pulls the data line low through an output-enable, in open-drain fashion. The whole register bank is presented as one flat parallel output, so the logic it configures can read every byte at once.

Every transfer names a starting register and is byte-counted. To write, the host sends the write address (0xDC), a beginning index, a count and then the data bytes, which land in consecutive registers. To read, the host sends the write address and the index, then a repeated start and the read address (0xDD). The slave answers with a count byte taken from register 8, then streams registers from the index onward. It continues until the host withholds its acknowledge.

The control state machine has these states: IDLE, ADDR (address byte), ADDR_ACK, INDEX, INDEX_ACK, COUNT, COUNT_ACK, WDATA, WDATA_ACK, TX (slave sends a byte), TX_ACK (host acknowledge slot) and SKIP (silent until the next condition).

Transitions:
- A stop leads from any state to IDLE.
- A start or repeated start leads from any state to ADDR.
- ADDR goes to ADDR_ACK on a matching address and to SKIP otherwise.
- ADDR_ACK goes to INDEX for a write, or to TX for a read.
- Each remaining receive state goes to its ACK state after eight bits.
- INDEX_ACK goes to COUNT, COUNT_ACK goes to WDATA, and WDATA_ACK goes back to WDATA.
- TX goes to TX_ACK after eight bits.
- TX_ACK goes back to TX when the host acknowledges, and to SKIP when it does not.

Top module: `cfg_blk_slave`

## Requirements
- R1: After reset, `regs_o` carries the reset values: register 0 = 0xA5, register 8 = 0x04, all others 0x00. `sda_oe_o` is low.
- R2: The slave acknowledges the address bytes 0xDC and 0xDD. Any other address byte gets no acknowledge. The slave then stays silent and ignores every later byte (even 0xDC) until the next start condition.
- R3: A block write (0xDC, index N, count X, data) stores the data bytes in registers N, N+1, ... in order. The slave acknowledges the address, index, count and each counted data byte.
- R4: Data bytes beyond the count X get no acknowledge and are not stored. With X = 0, the first data byte is already refused.
- R5: The register index advances by one after each data byte, in both directions, and wraps from 15 to 0.
- R6: Register 0 is read-only. Writes to it are acknowledged but leave its value unchanged, and the index still advances past it.
- R7: A block read (0xDC, N, repeated start, 0xDD) returns first the value of register 8, then registers N, N+1, ... most significant bit first.
- R8: Writing register 8 changes the count byte returned by later reads.
- R9: When the host does not acknowledge a read byte, the slave releases the data line at once. It does not drive the following bit times. A subsequent start begins a fresh transaction that is acknowledged normally.
- R10: A start or stop in the middle of a byte abandons that byte and does not store it. Bytes completed earlier in the same transfer keep their values. A start restarts address reception.
- R11: The slave changes its data-line drive only while the clock line is low, as seen by the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe_o | output | 1 | High to pull the data line low |
| regs_o | output | NREGS*8 (128) | Register bank, register k in bits 8k+7:8k |

## Verification
The bench builds the block with its defaults:
- 16 registers, so a three-byte write starting at index 14 crosses the wrap.
- Only register 0 read-only, with reset value 0xA5, so a single write through the wrap shows a refused store next to accepted ones.
- Register 8 as the count register with reset value 4, so short reads run out of the box and rewriting the count is visible in the next read.
- Two synchronizer stages and a bus half-period of 20 system clocks, which leave room for the detection latency before each bus edge.

// File: rtl/cfgbs_pkg.sv
`timescale 1ns/1ps
package cfgbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } cfgbs_state_e;

endpackage

// File: rtl/cfgbs_line_sync.sv
`timescale 1ns/1ps
module cfgbs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    // idle bus level is high on both lines
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // data edges with the clock held high are bus conditions
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/cfgbs_regbank.sv
`timescale 1ns/1ps
module cfgbs_regbank #(
    parameter int                    NREGS   = 16,
    parameter int                    IDXW    = 4,
    parameter logic [NREGS-1:0]      RO_MASK = '0,
    parameter logic [NREGS*8-1:0]    RST_VAL = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [IDXW-1:0]      rd_idx,
    output logic [7:0]           rd_data,
    output logic [NREGS*8-1:0]   regs_o
);

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (RO_MASK[g]) begin : g_ro
            assign regs_o[g*8 +: 8] = RST_VAL[g*8 +: 8];
        end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= RST_VAL[g*8 +: 8];
                end else if (wr_en && (wr_idx == IDXW'(g))) begin
                    q <= wr_data;
                end
            end
            assign regs_o[g*8 +: 8] = q;
        end
    end

    assign rd_data = regs_o[rd_idx*8 +: 8];

endmodule

// File: rtl/cfg_blk_slave.sv
`timescale 1ns/1ps
module cfg_blk_slave
    import cfgbs_pkg::*;
#(
    parameter logic [6:0]           DEV_ADDR = 7'h6E,
    parameter int                   NREGS    = 16,
    parameter int                   CNT_IDX  = 8,
    parameter logic [NREGS-1:0]     RO_MASK  = 16'h0001,
    parameter logic [NREGS*8-1:0]   RST_VAL  = 128'h0000000000000004_00000000000000A5,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic [NREGS*8-1:0]   regs_o
);

    localparam int IDXW = $clog2(NREGS);

    // line conditioning
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    cfgbs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // control state and datapath registers
    cfgbs_state_e     st, nxt;
    logic [3:0]       bitcnt;
    logic [6:0]       rxsh;
    logic [6:0]       txsh;
    logic [IDXW-1:0]  idx;
    logic [7:0]       remain;
    logic             rd_sel;
    logic             ack_phase;
    logic             ack_en;
    logic             sda_oe_q;
    logic             wr_en;
    logic [IDXW-1:0]  wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       rd_data;
    logic [7:0]       cnt_val;

    logic [7:0] rx_byte;
    logic       byte_done;
    logic       addr_hit;

    assign rx_byte   = {rxsh, sda_s};
    assign byte_done = scl_rise && (bitcnt == 4'd7);
    assign addr_hit  = (rx_byte[7:1] == DEV_ADDR);
    assign cnt_val   = regs_o[CNT_IDX*8 +: 8];

    cfgbs_regbank #(
        .NREGS   (NREGS),
        .IDXW    (IDXW),
        .RO_MASK (RO_MASK),
        .RST_VAL (RST_VAL)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next-state logic; bus conditions take priority over everything
    always_comb begin
        nxt = st;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && ack_phase) nxt = rd_sel ? ST_TX : ST_INDEX;
                end
                ST_INDEX: begin
                    if (byte_done) nxt = ST_INDEX_ACK;
                end
                ST_INDEX_ACK: begin
                    if (scl_fall && ack_phase) nxt = ST_COUNT;
                end
                ST_COUNT: begin
                    if (byte_done) nxt = ST_COUNT_ACK;
                end
                ST_COUNT_ACK: begin
                    if (scl_fall && ack_phase) nxt = ST_WDATA;
                end
                ST_WDATA: begin
                    if (byte_done) nxt = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall && ack_phase) nxt = ST_WDATA;
                end
                ST_TX: begin
                    if (scl_fall && (bitcnt == 4'd8)) nxt = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_s)              nxt = ST_SKIP;
                    else if (scl_fall && ack_phase)     nxt = ST_TX;
                end
                ST_SKIP: nxt = ST_SKIP;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_q  <= 1'b0;
            bitcnt    <= '0;
            rxsh      <= '0;
            txsh      <= '0;
            idx       <= '0;
            remain    <= '0;
            rd_sel    <= 1'b0;
            ack_phase <= 1'b0;
            ack_en    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det || start_det) begin
                sda_oe_q  <= 1'b0;
                bitcnt    <= '0;
                ack_phase <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                        if (scl_rise) begin
                            rxsh   <= rx_byte[6:0];
                            bitcnt <= bitcnt + 4'd1;
                            if (bitcnt == 4'd7) begin
                                bitcnt    <= '0;
                                ack_phase <= 1'b0;
                                ack_en    <= 1'b1;
                                if (st == ST_ADDR) begin
                                    rd_sel <= rx_byte[0];
                                    ack_en <= addr_hit;
                                end else if (st == ST_INDEX) begin
                                    idx <= rx_byte[IDXW-1:0];
                                end else if (st == ST_COUNT) begin
                                    remain <= rx_byte;
                                end else if (remain != 8'd0) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= rx_byte;
                                    idx     <= idx + IDXW'(1);
                                    remain  <= remain - 8'd1;
                                end else begin
                                    ack_en <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            if (!ack_phase) begin
                                ack_phase <= 1'b1;
                                sda_oe_q  <= ack_en;
                            end else begin
                                ack_phase <= 1'b0;
                                bitcnt    <= '0;
                                sda_oe_q  <= 1'b0;
                                if ((st == ST_ADDR_ACK) && rd_sel) begin
                                    txsh     <= cnt_val[6:0];
                                    sda_oe_q <= ~cnt_val[7];
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe_q  <= 1'b0;
                                bitcnt    <= '0;
                                ack_phase <= 1'b0;
                            end else begin
                                txsh     <= {txsh[5:0], 1'b0};
                                sda_oe_q <= ~txsh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && !sda_s) begin
                            ack_phase <= 1'b1;
                        end else if (scl_fall && ack_phase) begin
                            txsh      <= rd_data[6:0];
                            sda_oe_q  <= ~rd_data[7];
                            idx       <= idx + IDXW'(1);
                            ack_phase <= 1'b0;
                            bitcnt    <= '0;
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        sda_oe_q <= 1'b0;
                        bitcnt   <= '0;
                    end
                    default: begin
                        sda_oe_q <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_oe_o = sda_oe_q;

endmodule

// File: rtl/cfgbs_checker.sv
`timescale 1ns/1ps
module cfgbs_checker
    import cfgbs_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         scl_s,
    input logic         start_det,
    input logic         stop_det,
    input logic         sda_oe,
    input cfgbs_state_e st,
    input logic [3:0]   bitcnt,
    input logic         wr_en,
    input logic [7:0]   remain
);

    // R11: drive changes only follow a low clock (or a bus condition)
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

    // R2: silent in idle and after a refused address
    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_SKIP) || (st == ST_IDLE)) |-> !sda_oe);

    // R4: a store only happens while the count is not used up
    p_write_counted_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(remain) != 8'd0));

    // R9: the host acknowledge slot is never driven by the slave
    p_txack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX_ACK) |-> !sda_oe);

    // R10: a stop releases the line and returns to idle
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && (st == ST_IDLE)));

    // R10: a start restarts address reception from bit zero
    p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> ((st == ST_ADDR) && (bitcnt == 4'd0)));

endmodule

bind cfg_blk_slave cfgbs_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .st        (st),
    .bitcnt    (bitcnt),
    .wr_en     (wr_en),
    .remain    (remain)
);

// File: tb/cfg_blk_slave_tb.sv
`timescale 1ns/1ps
module cfg_blk_slave_tb;

    localparam int            NREGS   = 16;
    localparam int            CNT_IDX = 8;
    localparam logic [15:0]   RO_MASK = 16'h0001;
    localparam logic [127:0]  RST_VAL = 128'h0000000000000004_00000000000000A5;
    localparam int            HALF    = 20;

    // idx, count, bytes sent, d0, d1, d2
    localparam logic [47:0] VEC [6] = '{
        {8'd2,  8'd3, 8'd3, 8'h11, 8'h22, 8'h33},
        {8'd14, 8'd3, 8'd3, 8'h44, 8'h55, 8'h66},
        {8'd5,  8'd1, 8'd3, 8'h77, 8'h88, 8'h99},
        {8'd8,  8'd1, 8'd1, 8'h06, 8'h00, 8'h00},
        {8'd9,  8'd0, 8'd1, 8'hEE, 8'h00, 8'h00},
        {8'd12, 8'd2, 8'd2, 8'hC1, 8'hC2, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_scl = 1'b1;
    logic          host_sda = 1'b1;
    logic          sda_oe;
    logic          sda_bus;
    logic [127:0]  regs;
    logic          done = 1'b0;

    int checks = 0;
    int errors = 0;
    int viol = 0;
    logic prev_oe = 1'b0;

    logic [7:0] mdl [16];
    logic [7:0] wdat [3];
    logic [7:0] rbuf [16];

    always #2.5 clk = ~clk;

    assign sda_bus = host_sda & ~sda_oe;

    cfg_blk_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // R11 monitor: drive must not move while the host holds the clock high
    always @(negedge clk) begin
        if (rst_n) begin
            if ((sda_oe !== prev_oe) && host_scl) viol++;
            prev_oe = sda_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] pack_mdl();
        logic [127:0] r;
        for (int k = 0; k < NREGS; k++) r[k*8 +: 8] = mdl[k];
        return r;
    endfunction

    task automatic mdl_write(input int idx, input int cnt, input int n);
        for (int k = 0; k < n; k++) begin
            if (k < cnt && !RO_MASK[(idx + k) % NREGS]) mdl[(idx + k) % NREGS] = wdat[k];
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clock_bit(input logic b, output logic r);
        host_sda = b;
        tick(HALF);
        host_scl = 1'b1;
        tick(HALF / 2);
        r = sda_bus;
        tick(HALF / 2);
        host_scl = 1'b0;
        tick(2);
    endtask

    task automatic do_start();
        host_scl = 1'b0; tick(HALF);
        host_sda = 1'b1; tick(HALF);
        host_scl = 1'b1; tick(HALF);
        host_sda = 1'b0; tick(HALF);
        host_scl = 1'b0; tick(HALF);
    endtask

    task automatic do_stop();
        host_scl = 1'b0; tick(HALF);
        host_sda = 1'b0; tick(HALF);
        host_scl = 1'b1; tick(HALF);
        host_sda = 1'b1; tick(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
        clock_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clock_bit(nack, r);
    endtask

    task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt,
                             input int n, output logic [5:0] acks);
        logic a;
        acks = '0;
        do_start();
        wr_byte(8'hDC, a); acks[0] = a;
        wr_byte(idx, a);   acks[1] = a;
        wr_byte(cnt, a);   acks[2] = a;
        for (int k = 0; k < n; k++) begin
            wr_byte(wdat[k], a);
            acks[3 + k] = a;
        end
        do_stop();
    endtask

    task automatic blk_read(input logic [7:0] idx, input int n,
                            output logic [7:0] cbyte, output logic [2:0] acks);
        logic a;
        do_start();
        wr_byte(8'hDC, a); acks[0] = a;
        wr_byte(idx, a);   acks[1] = a;
        do_start();
        wr_byte(8'hDD, a); acks[2] = a;
        rd_byte(n == 0, cbyte);
        for (int k = 0; k < n; k++) rd_byte(k == n - 1, rbuf[k]);
        do_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0]  acks;
        logic [5:0]  exp_acks;
        logic [2:0]  racks;
        logic [7:0]  cbyte;
        logic [7:0]  b;
        logic        a;
        logic        r;
        int          idx;
        int          cnt;
        int          n;
        int          nread;
        int          busy;

        for (int k = 0; k < NREGS; k++) mdl[k] = RST_VAL[k*8 +: 8];

        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk(regs == RST_VAL, "R1", "reset register values", regs, RST_VAL);
        chk(sda_oe == 1'b0, "R1", "reset drive", 128'(sda_oe), 128'd0);

        // table-driven block writes, each followed by a block read
        for (int v = 0; v < 6; v++) begin
            idx = int'(VEC[v][47:40]);
            cnt = int'(VEC[v][39:32]);
            n   = int'(VEC[v][31:24]);
            wdat[0] = VEC[v][23:16];
            wdat[1] = VEC[v][15:8];
            wdat[2] = VEC[v][7:0];
            blk_write(VEC[v][47:40], VEC[v][39:32], n, acks);
            exp_acks = 6'b000111;
            for (int k = 0; k < n; k++) if (k < cnt) exp_acks[3 + k] = 1'b1;
            // R3 acks for counted bytes; R4 refusal past the count
            chk(acks == exp_acks, "R3/R4", "write acknowledge pattern", 128'(acks), 128'(exp_acks));
            mdl_write(idx, cnt, n);
            // R3 stores, R5 wrap, R6 read-only, R8 count register
            chk(regs == pack_mdl(), "R3/R5/R6", "bank after write", regs, pack_mdl());

            nread = int'(mdl[CNT_IDX]);
            blk_read(VEC[v][47:40], nread, cbyte, racks);
            chk(racks == 3'b111, "R7", "read address acks", 128'(racks), 128'd7);
            chk(cbyte == mdl[CNT_IDX], "R7 R8", "count byte", 128'(cbyte), 128'(mdl[CNT_IDX]));
            for (int k = 0; k < nread; k++) begin
                chk(rbuf[k] == mdl[(idx + k) % NREGS], "R7 R5", "read data byte",
                    128'(rbuf[k]), 128'(mdl[(idx + k) % NREGS]));
            end
        end

        // R2: foreign address refused, then silence until the next start
        do_start();
        wr_byte(8'hA0, a);
        chk(a == 1'b0, "R2", "foreign address ack", 128'(a), 128'd0);
        wr_byte(8'hDC, a);
        chk(a == 1'b0, "R2", "byte after refusal ack", 128'(a), 128'd0);
        wr_byte(8'h03, a);
        do_stop();
        chk(regs == pack_mdl(), "R2", "bank untouched", regs, pack_mdl());

        // R10: stop in the middle of a data byte
        do_start();
        wr_byte(8'hDC, a);
        wr_byte(8'h03, a);
        wr_byte(8'h02, a);
        wr_byte(8'h5A, a);
        chk(a == 1'b1, "R10", "committed byte ack", 128'(a), 128'd1);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, r);
        do_stop();
        mdl[3] = 8'h5A;
        chk(regs == pack_mdl(), "R10", "bank after stop abort", regs, pack_mdl());

        // R10: start in the middle of a byte restarts the transfer
        do_start();
        wr_byte(8'hDC, a);
        for (int i = 0; i < 3; i++) clock_bit(1'b0, r);
        wdat[0] = 8'h6B;
        blk_write(8'd10, 8'd1, 1, acks);
        chk(acks[3:0] == 4'b1111, "R10", "acks after restart", 128'(acks[3:0]), 128'hF);
        mdl_write(10, 1, 1);
        chk(regs == pack_mdl(), "R10", "bank after restart", regs, pack_mdl());

        // R9: host refuses the first data byte, slave goes quiet, new start works
        do_start();
        wr_byte(8'hDC, a);
        wr_byte(8'h02, a);
        do_start();
        wr_byte(8'hDD, a);
        rd_byte(1'b0, cbyte);
        rd_byte(1'b1, b);
        chk(b == mdl[2], "R9", "byte before refusal", 128'(b), 128'(mdl[2]));
        busy = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            if (sda_oe) busy++;
            tick(1);
        end
        chk(busy == 0, "R9", "drive after refusal", 128'(busy), 128'd0);
        wdat[0] = 8'h3C;
        blk_write(8'd6, 8'd1, 1, acks);
        chk(acks[3:0] == 4'b1111, "R9", "acks of next transaction", 128'(acks[3:0]), 128'hF);
        mdl_write(6, 1, 1);
        chk(regs == pack_mdl(), "R9", "bank after next transaction", regs, pack_mdl());

        // R11: drive only moves while the clock is low
        chk(viol == 0, "R11", "drive changes with clock high", 128'(viol), 128'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule